// File: doc/BRIEF.md
# General-Purpose Bidirectional I/O Port

This block is one byte-wide (parameterizable) general-purpose I/O port on a simple CPU register bus. It holds two registers: an output data latch and a per-bit direction register. Each pad line is either a push-pull output that drives the latched value or an input. The input may have a pull-up enable flag, which is active only when a build-time mask selects that line. The analog pad cells sit outside the block. The block drives only the output values, the output enables and the pull-up enable flags.

Software reaches the two registers at a pair of adjacent addresses. The latch is at the even base address and the direction register is at the next odd address. A write either loads the whole byte or sets or clears one selected bit, and each kind of write completes in a single clock edge. A read of the latch address returns a per-bit mix. Input lines give the pad level as sampled at the read edge. Output lines give the latch contents. This lets software read a value, change it and write it back without losing the driven levels.

Top module: `gpio_port`

## Requirements
- R1: After reset the data latch and the direction register are all ones: pad_out is all ones, pad_oe is all zeros, bus_rdata is zero and bus_rvalid is low.
- R2: The data latch answers at BASE_ADDR (even) and the direction register at BASE_ADDR+1. An access to any other address changes no register, leaves pad_out and pad_oe unchanged and raises no bus_rvalid.
- R3: A write with bus_op=0 (byte) to BASE_ADDR loads bus_wdata into the latch at the next clock edge, so pad_out shows it after that edge. It holds until the latch is written again, whatever pad_in does.
- R4: A direction bit of 1 makes its line an input (pad_oe bit 0). A direction bit of 0 makes it an output (pad_oe bit 1). A byte write to BASE_ADDR+1 takes effect at the next edge.
- R5: bus_op=1 sets and bus_op=2 clears only the bit numbered bus_bit of the addressed register, at the same edge a byte write would use. All other bits keep their value.
- R6: A write with bus_op=3 is ignored and leaves both registers unchanged.
- R7: A read (bus_en=1, bus_we=0) of BASE_ADDR drives bus_rdata one edge later. Bit i is pad_in[i] as sampled at the read edge when direction bit i is 1, and the latch bit otherwise. Inputs are not held, so a later read reflects a changed pad.
- R8: A read of BASE_ADDR+1 returns the direction register one edge later.
- R9: bus_rvalid is high for exactly one cycle after each read of either register address. bus_rdata holds its value between reads.
- R10: pad_pullup_en[i] is high only when direction bit i is 1 and PULLUP_MASK[i] is 1. It is never high on an output line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_op | input | 2 | Write kind: 0 byte, 1 set bit, 2 clear bit, 3 ignored |
| bus_bit | input | IDX_W | Bit number for set and clear |
| bus_wdata | input | WIDTH | Write data for byte writes |
| bus_rdata | output | WIDTH | Read data, registered |
| bus_rvalid | output | 1 | One-cycle read-data strobe |
| pad_in | input | WIDTH | Pad levels |
| pad_out | output | WIDTH | Output values to pads |
| pad_oe | output | WIDTH | Output enables, 1 = drive |
| pad_pullup_en | output | WIDTH | Pull-up enables for input lines |

## Verification
A corrupted latch bit shows at pad_out on the edge after the write that caused it, and a corrupted direction bit shows at pad_oe and pad_pullup_en at the same point. The bench therefore compares all three after every write. A wrong read-path select is hidden while every line has the same direction. For that reason reads are made with mixed direction settings and with pad levels that differ from the latch, so a swapped source shows in the bus_rdata that follows one edge later. An access that hits a foreign address would show as an unexpected bus_rvalid or a changed pad output in the next cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      GP_OP_BYTE = 2'd0,
      GP_OP_SET  = 2'd1,
      GP_OP_CLR  = 2'd2,
      GP_OP_RSVD = 2'd3
   } gp_op_e;

endpackage

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
   import gpio_port_pkg::*;
#(
   parameter int WIDTH = 8,
   parameter int IDX_W = 3,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  gp_op_e           op,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] sel_mask;
   logic [WIDTH-1:0] q_nxt;

   for (genvar i = 0; i < WIDTH; i++) begin : g_sel
      assign sel_mask[i] = (bit_idx == IDX_W'(i));
   end

   always_comb begin
      q_nxt = q;
      if (wr_en) begin
         case (op)
            GP_OP_BYTE: q_nxt = wdata;
            GP_OP_SET:  q_nxt = q | sel_mask;
            GP_OP_CLR:  q_nxt = q & ~sel_mask;
            default:    q_nxt = q;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= RST_VAL;
      else        q <= q_nxt;
   end

   a_r3_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && op == GP_OP_BYTE |=> q == $past(wdata));

   a_r5_set_bit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && op == GP_OP_SET |=> (q & $past(sel_mask)) == $past(sel_mask));

   a_r5_clr_bit: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && op == GP_OP_CLR |=> (q & $past(sel_mask)) == '0);

   a_r5_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (op == GP_OP_SET || op == GP_OP_CLR)
      |=> ((q ^ $past(q)) & ~$past(sel_mask)) == '0);

   a_r6_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || op == GP_OP_RSVD) |=> $stable(q));

endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_data,
   input  logic             rd_dir,
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   input  logic [WIDTH-1:0] pad_in,
   output logic [WIDTH-1:0] rdata,
   output logic             rvalid
);

   logic [WIDTH-1:0] mixed;

   for (genvar i = 0; i < WIDTH; i++) begin : g_mix
      assign mixed[i] = dir_q[i] ? pad_in[i] : latch_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd_data | rd_dir;
         if (rd_data)     rdata <= mixed;
         else if (rd_dir) rdata <= dir_q;
      end
   end

   a_r9_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data || rd_dir) |=> rvalid);

   a_r9_no_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_data || rd_dir) |=> !rvalid && $stable(rdata));

   a_r8_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
      rd_dir |=> rdata == $past(dir_q));

   a_r7_output_bits_from_latch: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data |=> ((rdata ^ $past(latch_q)) & ~$past(dir_q)) == '0);

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
   parameter int WIDTH = 8,
   parameter logic [WIDTH-1:0] PULLUP_MASK = '0
) (
   input  logic [WIDTH-1:0] latch_q,
   input  logic [WIDTH-1:0] dir_q,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   output logic [WIDTH-1:0] pad_pullup_en
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_pad
      assign pad_out[i] = latch_q[i];
      assign pad_oe[i]  = ~dir_q[i];
      if (PULLUP_MASK[i]) begin : g_pu
         assign pad_pullup_en[i] = dir_q[i];
      end else begin : g_nopu
         assign pad_pullup_en[i] = 1'b0;
      end
   end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter int ADDR_W = 8,
   parameter int BASE_ADDR = 32,
   parameter logic [WIDTH-1:0] PULLUP_MASK = 8'h0F,
   localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_op,
   input  logic [IDX_W-1:0]  bus_bit,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   output logic              bus_rvalid,
   input  logic [WIDTH-1:0]  pad_in,
   output logic [WIDTH-1:0]  pad_out,
   output logic [WIDTH-1:0]  pad_oe,
   output logic [WIDTH-1:0]  pad_pullup_en
);

   localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(BASE_ADDR);
   localparam logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(BASE_ADDR + 1);

   if (WIDTH < 1) begin : g_bad_width
      $error("gpio_port: WIDTH must be at least 1");
   end
   if ((BASE_ADDR % 2) != 0) begin : g_bad_base
      $error("gpio_port: BASE_ADDR must be even");
   end
   if (BASE_ADDR + 1 >= (1 << ADDR_W)) begin : g_bad_range
      $error("gpio_port: BASE_ADDR+1 does not fit in ADDR_W bits");
   end

   logic   hit_data, hit_dir;
   logic   wr_data, wr_dir, rd_data, rd_dir;
   gp_op_e op;
   logic [WIDTH-1:0] latch_q, dir_q;

   assign op       = gp_op_e'(bus_op);
   assign hit_data = bus_en && (bus_addr == DATA_ADDR);
   assign hit_dir  = bus_en && (bus_addr == DIR_ADDR);
   assign wr_data  = hit_data &&  bus_we;
   assign wr_dir   = hit_dir  &&  bus_we;
   assign rd_data  = hit_data && !bus_we;
   assign rd_dir   = hit_dir  && !bus_we;

   gpio_reg_bank #(.WIDTH(WIDTH), .IDX_W(IDX_W), .RST_VAL('1)) i_latch (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_data), .op(op),
      .bit_idx(bus_bit), .wdata(bus_wdata), .q(latch_q)
   );

   gpio_reg_bank #(.WIDTH(WIDTH), .IDX_W(IDX_W), .RST_VAL('1)) i_dir (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_dir), .op(op),
      .bit_idx(bus_bit), .wdata(bus_wdata), .q(dir_q)
   );

   gpio_read_path #(.WIDTH(WIDTH)) i_rd (
      .clk(clk), .rst_n(rst_n), .rd_data(rd_data), .rd_dir(rd_dir),
      .latch_q(latch_q), .dir_q(dir_q), .pad_in(pad_in),
      .rdata(bus_rdata), .rvalid(bus_rvalid)
   );

   gpio_pad_drive #(.WIDTH(WIDTH), .PULLUP_MASK(PULLUP_MASK)) i_pad (
      .latch_q(latch_q), .dir_q(dir_q),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_pullup_en(pad_pullup_en)
   );

   a_r4_oe_after_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_en && bus_we && bus_addr == DIR_ADDR && bus_op == 2'd0
      |=> pad_oe == ~$past(bus_wdata));

   a_r2_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
      bus_en && bus_addr != DATA_ADDR && bus_addr != DIR_ADDR
      |=> $stable(pad_out) && $stable(pad_oe) && !bus_rvalid);

   a_r10_pullup_only_inputs: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pullup_en & pad_oe) == '0);

   a_r3_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_en && bus_we && bus_addr == DATA_ADDR) |=> $stable(pad_out));

endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;

   localparam int W = 8;
   localparam int BASE = 32;
   localparam logic [W-1:0] PU = 8'h0F;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0] bus_addr = '0;
   logic [1:0] bus_op = '0;
   logic [2:0] bus_bit = '0;
   logic [W-1:0] bus_wdata = '0, pad_in = '0;
   logic [W-1:0] bus_rdata, pad_out, pad_oe, pad_pullup_en;
   logic bus_rvalid;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] m_lat, m_dir;
   logic [W-1:0] exp_q[$];
   string tag_q[$];

   always #5 clk = ~clk;

   gpio_port #(.WIDTH(W), .ADDR_W(8), .BASE_ADDR(BASE), .PULLUP_MASK(PU)) i_gpio_port (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_op(bus_op), .bus_bit(bus_bit),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_pullup_en(pad_pullup_en)
   );

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] apply(input logic [W-1:0] cur, input logic [1:0] op,
                                          input logic [2:0] b, input logic [W-1:0] d);
      case (op)
         2'd0: return d;
         2'd1: return cur | (W'(1) << b);
         2'd2: return cur & ~(W'(1) << b);
         default: return cur;
      endcase
   endfunction

   task automatic wr(input logic [7:0] a, input logic [1:0] op, input logic [2:0] b,
                     input logic [W-1:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_op = op; bus_bit = b; bus_wdata = d;
      if (a == 8'(BASE))     m_lat = apply(m_lat, op, b, d);
      if (a == 8'(BASE + 1)) m_dir = apply(m_dir, op, b, d);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
      if (a == 8'(BASE)) begin
         exp_q.push_back((pad_in & m_dir) | (m_lat & ~m_dir));
         tag_q.push_back(tag);
      end else if (a == 8'(BASE + 1)) begin
         exp_q.push_back(m_dir);
         tag_q.push_back(tag);
      end
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic chk_pads(input string tag);
      chk({tag, " pad_out"}, pad_out, m_lat);
      chk({tag, " pad_oe"}, pad_oe, ~m_dir);
      chk({"R10 ", tag, " pullup"}, pad_pullup_en, m_dir & PU);
   endtask

   // monitor: compares read results against the scoreboard
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2/R9 unexpected rvalid actual=%h expected=none", bus_rdata);
         end else begin
            chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      m_lat = '1; m_dir = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 pad_out", pad_out, 8'hFF);
      chk("R1 pad_oe", pad_oe, 8'h00);
      chk("R1 rdata", bus_rdata, 8'h00);
      chk("R1 rvalid", {7'd0, bus_rvalid}, 8'h00);
      chk("R10 reset pullup", pad_pullup_en, PU);

      pad_in = 8'hA5;
      rd(8'(BASE), "R7 all-input read");
      rd(8'(BASE + 1), "R8 dir read at reset");

      wr(8'(BASE), 2'd0, 3'd0, 8'h3C);
      chk_pads("R3 byte write");
      pad_in = 8'h00;
      @(negedge clk);
      chk("R3 latch held vs pad", pad_out, 8'h3C);

      wr(8'(BASE + 1), 2'd0, 3'd0, 8'h0F);
      chk_pads("R4 dir write");

      pad_in = 8'h5A;
      rd(8'(BASE), "R7 mixed read");
      pad_in = 8'hA5;
      rd(8'(BASE), "R7 pad not latched");
      rd(8'(BASE), "R9 back-to-back read");
      rd(8'(BASE + 1), "R8 dir read");

      wr(8'(BASE), 2'd1, 3'd7, 8'h00);
      chk_pads("R5 set bit7");
      wr(8'(BASE), 2'd2, 3'd2, 8'hFF);
      chk_pads("R5 clear bit2");
      wr(8'(BASE + 1), 2'd2, 3'd3, 8'h00);
      chk_pads("R5 clear dir bit3");
      wr(8'(BASE + 1), 2'd1, 3'd6, 8'h00);
      chk_pads("R5 set dir bit6");

      wr(8'(BASE), 2'd3, 3'd0, 8'h00);
      chk_pads("R6 rsvd data");
      wr(8'(BASE + 1), 2'd3, 3'd1, 8'hFF);
      chk_pads("R6 rsvd dir");

      wr(8'(BASE + 2), 2'd0, 3'd0, 8'h00);
      chk_pads("R2 foreign write");
      wr(8'(BASE - 1), 2'd0, 3'd0, 8'h00);
      chk_pads("R2 foreign write below");
      rd(8'(BASE + 2), "R2 foreign read");
      @(negedge clk);
      chk("R2 no rvalid", {7'd0, bus_rvalid}, 8'h00);

      // read-modify-write of the latch through the port
      pad_in = 8'h0F;
      rd(8'(BASE), "R7 rmw read");
      wr(8'(BASE), 2'd0, 3'd0, ((8'h0F & m_dir) | (m_lat & ~m_dir)) ^ 8'h80);
      chk_pads("R3 rmw write");

      wr(8'(BASE + 1), 2'd0, 3'd0, 8'h00);
      chk_pads("R4 all outputs");
      rd(8'(BASE), "R7 all-output read");
      repeat (2) @(negedge clk);
      chk("R9 queue drained", 8'(exp_q.size()), 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule